// File: doc/BRIEF.md
# DMA Channel Request Gating and Status

This block holds the enable, pending-request and completion state for each channel of a small DMA controller. Each channel has a mask bit. The mask gates both the channel's hardware request line and a request raised by software. The combined, gated request vector goes to a separate priority arbiter. A software request lets a program start a transfer, for example memory to memory, when no device drives a request line.

Software reaches the block through one command port. An operation code picks what to do: mask or unmask one channel, load every mask in one write, or raise or drop one channel's software request. The address logic pulses a per-channel terminal-count input when a channel has moved its last byte. The block keeps a sticky flag for each pulse. A readable status byte carries these flags in its low half. Its high half carries the live, unmasked hardware request lines.

Each channel's software request runs as a small state machine with three states. `SW_IDLE` means no software request. `SW_HELD` means a request is pending but the channel is masked. `SW_LIVE` means a request is pending and the channel is enabled. The transitions are:
- IDLE→HELD or IDLE→LIVE on a set command, chosen by the mask value in force after that edge.
- HELD↔LIVE when the mask changes.
- HELD/LIVE→IDLE on a clear command, or on a terminal count with no set command in the same cycle.

Top module: `dma_reqmask`

## Requirements
- R1: After reset every mask bit is 1, every terminal-count flag is 0, no software request is pending, and `req_vec` is 0.
- R2: `cmd_op`=2'b01 is the single-mask command. `cmd_data[1:0]` selects the channel and `cmd_data[2]` is the new mask value (1 disables). Only that channel's mask changes, and it is visible on `mask_o` after the next clock edge.
- R3: `cmd_op`=2'b10 loads all masks, with `cmd_data[n]` going to channel n. The new masks are visible after the next clock edge.
- R4: `req_vec[n]` is 1 in the same cycle that `hw_req[n]` is 1 and channel n is unmasked. A masked channel's hardware request never reaches `req_vec`.
- R5: `cmd_op`=2'b11 is the software request command. `cmd_data[1:0]` selects the channel and `cmd_data[2]`=1 raises the request, 0 drops it. While the channel is unmasked, a raised request drives `req_vec[n]` high from the cycle after the command until it is dropped. `cmd_op`=2'b00 does nothing.
- R6: A software request raised on a masked channel stays pending with `req_vec[n]` low, and appears on `req_vec[n]` in the cycle after the channel is unmasked.
- R7: A pulse on `tc_hit[n]` drops channel n's software request at the next edge, unless a software command for channel n arrives in the same cycle, in which case the command decides.
- R8: `status_o[n]` (n = 0..3) becomes 1 the cycle after `tc_hit[n]` and stays 1 until a status read.
- R9: `status_rd` clears the terminal-count flags at the next edge. A channel whose `tc_hit` pulses in the read cycle keeps its flag set.
- R10: `status_o[4+n]` equals `hw_req[n]` in the same cycle, whatever the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req | input | 4 | Hardware request line per channel |
| cmd_op | input | 2 | Command code: 00 none, 01 single mask, 10 all masks, 11 software request |
| cmd_data | input | 4 | Command operand |
| tc_hit | input | 4 | Terminal-count pulse per channel from the address logic |
| status_rd | input | 1 | Status byte is being read this cycle |
| req_vec | output | 4 | Gated request vector to the arbiter |
| mask_o | output | 4 | Current mask bits |
| status_o | output | 8 | Low half: terminal-count flags; high half: live hardware requests |

## Verification
Some results are combinational and are due in the same cycle as their stimulus: the hardware-request path of `req_vec` and the high half of `status_o`. Every registered result is due exactly one edge after its stimulus: mask changes, software request changes, terminal-count flags and read clearing. The bench applies inputs at the falling edge and compares all outputs one time unit later against a behavioural model. It then advances the model by one step, so each registered effect is checked in the first cycle it is due and never before. The directed phases cover the same-cycle collisions (terminal count against a software command, terminal count against a read), and a random phase follows them.

// File: rtl/dma_reqmask_pkg.sv
package dma_reqmask_pkg;

    typedef enum logic [1:0] {
        OP_NONE    = 2'b00,
        OP_MASK1   = 2'b01,
        OP_MASKALL = 2'b10,
        OP_SWREQ   = 2'b11
    } cmd_op_t;

    typedef enum logic [1:0] {
        SW_IDLE = 2'b00,
        SW_HELD = 2'b01,
        SW_LIVE = 2'b10
    } sw_state_t;

endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
    import dma_reqmask_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic [1:0]     cmd_op,
    input  logic [NCH-1:0] cmd_data,
    output logic [NCH-1:0] mask_set,
    output logic [NCH-1:0] mask_clr,
    output logic           mask_load_en,
    output logic [NCH-1:0] mask_load_val,
    output logic [NCH-1:0] sw_set,
    output logic [NCH-1:0] sw_clr
);

    cmd_op_t        op;
    logic [CW-1:0]  sel;
    logic           val;

    assign op            = cmd_op_t'(cmd_op);
    assign sel           = cmd_data[CW-1:0];
    assign val           = cmd_data[CW];
    assign mask_load_en  = (op == OP_MASKALL);
    assign mask_load_val = cmd_data;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit         = (sel == CW'(g));
        assign mask_set[g] = (op == OP_MASK1) && hit && val;
        assign mask_clr[g] = (op == OP_MASK1) && hit && !val;
        assign sw_set[g]   = (op == OP_SWREQ) && hit && val;
        assign sw_clr[g]   = (op == OP_SWREQ) && hit && !val;
    end

    // Single-channel commands reach at most one channel per cycle
    always_comb begin
        assert ($onehot0(mask_set | mask_clr | sw_set | sw_clr))
            else $error("p_one_target_r2 violated");
    end

endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
    import dma_reqmask_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_req,
    input  logic mask_set,
    input  logic mask_clr,
    input  logic mask_load_en,
    input  logic mask_load_val,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic tc_hit,
    input  logic status_rd,
    output logic mask_q,
    output logic req_out,
    output logic tc_flag
);

    sw_state_t state_q, state_d;
    logic      mask_d;
    logic      tc_d;

    // Mask next value: bulk load and single-channel writes never coincide
    always_comb begin
        mask_d = mask_q;
        if (mask_load_en)  mask_d = mask_load_val;
        else if (mask_set) mask_d = 1'b1;
        else if (mask_clr) mask_d = 1'b0;
    end

    // Software request state machine: next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_IDLE: begin
                if (sw_set) state_d = mask_d ? SW_HELD : SW_LIVE;
            end
            SW_HELD, SW_LIVE: begin
                if (sw_set)                 state_d = mask_d ? SW_HELD : SW_LIVE;
                else if (sw_clr || tc_hit)  state_d = SW_IDLE;
                else                        state_d = mask_d ? SW_HELD : SW_LIVE;
            end
            default: state_d = SW_IDLE;
        endcase
    end

    assign tc_d = tc_hit || (tc_flag && !status_rd);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
            mask_q  <= 1'b1;
            tc_flag <= 1'b0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
            tc_flag <= tc_d;
        end
    end

    // Outputs
    always_comb begin
        req_out = hw_req && !mask_q;
        unique case (state_q)
            SW_LIVE: req_out = 1'b1;
            SW_IDLE, SW_HELD: ;
            default: ;
        endcase
    end

    p_live_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_LIVE) |-> !mask_q);

    p_held_to_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_HELD && mask_clr && !sw_clr && !tc_hit) |=> (state_q == SW_LIVE));

    p_single_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_set |=> mask_q);

    p_single_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_clr |=> !mask_q);

    p_tc_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tc_hit |=> tc_flag);

    p_rd_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !tc_hit) |=> !tc_flag);

    p_tc_drops_sw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_hit && !sw_set) |=> (state_q == SW_IDLE));

endmodule

// File: rtl/dma_reqmask.sv
module dma_reqmask
    import dma_reqmask_pkg::*;
#(
    parameter int NCH = 4,
    localparam int SW = 2 * NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hw_req,
    input  logic [1:0]     cmd_op,
    input  logic [NCH-1:0] cmd_data,
    input  logic [NCH-1:0] tc_hit,
    input  logic           status_rd,
    output logic [NCH-1:0] req_vec,
    output logic [NCH-1:0] mask_o,
    output logic [SW-1:0]  status_o
);

    logic [NCH-1:0] mask_set, mask_clr, mask_load_val, sw_set, sw_clr;
    logic [NCH-1:0] tc_flags;
    logic           mask_load_en;

    dma_cmd_decode #(.NCH(NCH)) u_dec (
        .cmd_op        (cmd_op),
        .cmd_data      (cmd_data),
        .mask_set      (mask_set),
        .mask_clr      (mask_clr),
        .mask_load_en  (mask_load_en),
        .mask_load_val (mask_load_val),
        .sw_set        (sw_set),
        .sw_clr        (sw_clr)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        dma_chan_slot u_slot (
            .clk           (clk),
            .rst_n         (rst_n),
            .hw_req        (hw_req[g]),
            .mask_set      (mask_set[g]),
            .mask_clr      (mask_clr[g]),
            .mask_load_en  (mask_load_en),
            .mask_load_val (mask_load_val[g]),
            .sw_set        (sw_set[g]),
            .sw_clr        (sw_clr[g]),
            .tc_hit        (tc_hit[g]),
            .status_rd     (status_rd),
            .mask_q        (mask_o[g]),
            .req_out       (req_vec[g]),
            .tc_flag       (tc_flags[g])
        );
    end

    assign status_o = {hw_req, tc_flags};

    p_no_masked_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vec & mask_o) == '0);

    p_bulk_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_MASKALL) |=> (mask_o == $past(cmd_data)));

    p_tc_flag_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_rd && tc_flags != '0) |=> ((tc_flags & $past(tc_flags)) == $past(tc_flags)));

endmodule

// File: tb/dma_reqmask_tb.sv
module dma_reqmask_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] hw_req = '0;
    logic [1:0] cmd_op = '0;
    logic [3:0] cmd_data = '0;
    logic [3:0] tc_hit = '0;
    logic       status_rd = 1'b0;
    logic [3:0] req_vec, mask_o;
    logic [7:0] status_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference state
    bit m_mask [4];
    bit m_sw   [4];
    bit m_tc   [4];
    string phase = "R1 reset";

    always #2 clk = ~clk;

    dma_reqmask u_dut (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .tc_hit(tc_hit), .status_rd(status_rd),
        .req_vec(req_vec), .mask_o(mask_o), .status_o(status_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", tag, phase, act, exp);
        end
    endtask

    task automatic compare();
        int em = 0, er = 0, et = 0;
        for (int i = 0; i < 4; i++) begin
            em |= int'(m_mask[i]) << i;
            if (!m_mask[i] && (hw_req[i] || m_sw[i])) er |= 1 << i;
            et |= int'(m_tc[i]) << i;
        end
        check("R2/R3 mask", mask_o, em);
        check("R4/R5/R6 req_vec", req_vec, er);
        check("R8/R9 tc flags", status_o[3:0], et);
        check("R10 live requests", status_o[7:4], hw_req);
    endtask

    task automatic step_model();
        int ch = cmd_data[1:0];
        bit v = cmd_data[2];
        for (int i = 0; i < 4; i++) begin
            bit swcmd = (cmd_op == 2'b11) && (ch == i);
            if (swcmd)          m_sw[i] = v;
            else if (tc_hit[i]) m_sw[i] = 0;
            m_tc[i] = tc_hit[i] || (m_tc[i] && !status_rd);
        end
        if (cmd_op == 2'b01) m_mask[ch] = v;
        if (cmd_op == 2'b10) for (int i = 0; i < 4; i++) m_mask[i] = cmd_data[i];
    endtask

    task automatic cyc(input logic [3:0] h, input logic [1:0] op, input logic [3:0] d,
                       input logic [3:0] t, input logic rd);
        @(negedge clk);
        hw_req = h; cmd_op = op; cmd_data = d; tc_hit = t; status_rd = rd;
        #1;
        compare();
        step_model();
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin m_mask[i] = 1; m_sw[i] = 0; m_tc[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, requests blocked by masks
        cyc(4'h0, 2'b00, 4'h0, 4'h0, 0);
        phase = "R4 masked hw";
        cyc(4'hF, 2'b00, 4'h0, 4'h0, 0);
        phase = "R3 bulk";
        cyc(4'hF, 2'b10, 4'b0101, 4'h0, 0);
        cyc(4'hF, 2'b10, 4'b0000, 4'h0, 0);
        cyc(4'hA, 2'b00, 4'h0, 4'h0, 0);
        phase = "R2 single";
        cyc(4'hF, 2'b01, 4'b0110, 4'h0, 0);   // mask ch2
        cyc(4'hF, 2'b01, 4'b0010, 4'h0, 0);   // unmask ch2
        cyc(4'hF, 2'b01, 4'b0111, 4'h0, 0);   // mask ch3
        phase = "R5 sw request";
        cyc(4'h0, 2'b11, 4'b0101, 4'h0, 0);   // raise ch1
        cyc(4'h0, 2'b00, 4'h0, 4'h0, 0);
        cyc(4'h0, 2'b11, 4'b0001, 4'h0, 0);   // drop ch1
        cyc(4'h0, 2'b00, 4'h0, 4'h0, 0);
        phase = "R6 held while masked";
        cyc(4'h0, 2'b11, 4'b0111, 4'h0, 0);   // raise ch3 (masked)
        cyc(4'h0, 2'b00, 4'h0, 4'h0, 0);
        cyc(4'h0, 2'b01, 4'b0011, 4'h0, 0);   // unmask ch3
        cyc(4'h0, 2'b00, 4'h0, 4'h0, 0);
        phase = "R7 tc drops sw";
        cyc(4'h0, 2'b00, 4'h0, 4'b1000, 0);
        cyc(4'h0, 2'b11, 4'b0100, 4'h0, 0);   // raise ch0
        cyc(4'h0, 2'b11, 4'b0100, 4'b0001, 0); // tc with set: stays
        cyc(4'h0, 2'b00, 4'h0, 4'h0, 0);
        phase = "R8 sticky tc";
        cyc(4'h0, 2'b00, 4'h0, 4'b0110, 0);
        cyc(4'h0, 2'b00, 4'h0, 4'h0, 0);
        phase = "R9 read clear";
        cyc(4'h0, 2'b00, 4'h0, 4'b0100, 1);   // ch2 re-hit keeps flag
        cyc(4'h0, 2'b00, 4'h0, 4'h0, 1);
        cyc(4'h0, 2'b00, 4'h0, 4'h0, 0);
        phase = "R10 random";
        for (int k = 0; k < 600; k++) begin
            cyc(4'($urandom), 2'($urandom), 4'($urandom),
                (($urandom % 4) == 0) ? 4'($urandom) : 4'h0, ($urandom % 5) == 0);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int w = 0; w < 20000; w++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog [%s] actual=hung expected=finished", phase);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule